// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block times one access to an external static memory bank. A start request on the internal side is accepted only when the sequencer is idle. At that point the block captures the direction of the access and the bank's programmed wait-state count. It then drives an active-low chip select together with exactly one active-low strobe: output enable for a read, or write enable for a write. The cycles are numbered from the first chip-select cycle, which counts as wait state one.

The external device can stretch an access through an active-low wait line. The line is sampled on every rising clock edge. It only counts if it is seen low at the end of wait state one or two. Once the access is stretched, the block holds until the line is seen high again, then runs three more cycles. The access never ends before the programmed count has elapsed. After the last active cycle, chip select and the strobe go inactive together, and a one-cycle done pulse is raised in that same cycle. The sequencer then returns to idle.

The states are IDLE, COUNT, STRETCH, TAIL and DONE, with these transitions:
- IDLE to COUNT on an accepted start.
- COUNT to STRETCH when the wait line is seen low within the recognition window.
- COUNT to DONE once the programmed count is reached.
- STRETCH to TAIL when the wait line is seen released.
- TAIL to DONE once three tail cycles have run and the count is also reached.
- DONE to IDLE always.

Top module: `smws_top`

## Requirements
- R1: A start request sampled high in IDLE makes chip select active from the next cycle. During the access, output enable is active for a read (req_write=0) and write enable is active for a write (req_write=1). Never both strobes are active, and no strobe is active while chip select is inactive.
- R2: The wait-state field is 5 bits wide. Values 0 and 1 are treated as 2.
- R3: With the wait line held high, chip select stays active for exactly N cycles, where N is the effective wait-state count.
- R4: The wait line (low = wait) may be seen low at the end of active cycle 1 or 2. In that case let r be the first later cycle at whose end it is seen high. The access then lasts max(N, r+3) active cycles.
- R5: A wait line that first goes low at active cycle 3 or later has no effect, and the access lasts N cycles.
- R6: The done output is high for exactly one cycle, namely the cycle right after the last active cycle. In that cycle chip select and both strobes are inactive. The block is idle in the following cycle.
- R7: A start request is ignored from acceptance through the done cycle. No extra access follows.
- R8: Under reset, chip select, output enable and write enable are inactive (high) and done is low.
- R9: Direction and wait count are captured at acceptance. Changing req_write or req_waits during an access does not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start an access (accepted in IDLE only) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waits | input | 5 | Programmed wait states for the bank |
| ext_wait_n | input | 1 | External wait line, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| acc_done | output | 1 | One-cycle end-of-access pulse |

## Verification
The hardest situation to reach from the ports is the boundary of the recognition window. A wait assertion in active cycle 2 must stretch the access, while the same assertion in cycle 3 must leave it untouched. The interplay of a short release with a long programmed count is equally delicate. The bench drives the wait line on falling edges, indexed by active-cycle number. Each scenario can therefore place the assertion and the release in an exact cycle relative to chip select. The bench also pokes start requests mid-access and in the done cycle to show they are dropped.

// File: rtl/smws_pkg.sv
package smws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_STRETCH,
        ST_TAIL,
        ST_DONE
    } smws_state_e;
endpackage

// File: rtl/smws_cfg.sv
// Captures direction and the clamped wait-state limit when an access is accepted.
module smws_cfg #(
    parameter int CNT_W     = 5,
    parameter int MIN_WAITS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             wr_in,
    input  logic [CNT_W-1:0] waits_in,
    output logic             wr_q,
    output logic [CNT_W-1:0] limit_q
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_WAITS);

    logic [CNT_W-1:0] clamped;

    always_comb begin
        clamped = (waits_in < FLOOR) ? FLOOR : waits_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            limit_q <= FLOOR;
        end else if (load) begin
            wr_q    <= wr_in;
            limit_q <= clamped;
        end
    end
endmodule

// File: rtl/smws_counters.sv
// Wait-state counter (1-based, saturating) and release tail counter.
module smws_counters #(
    parameter int CNT_W    = 5,
    parameter int TAIL_LEN = 3,
    localparam int TAIL_W  = $clog2(TAIL_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              tail_start,
    input  logic              tail_step,
    output logic [CNT_W-1:0]  cnt,
    output logic [TAIL_W-1:0] tail
);
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [TAIL_W-1:0] TAIL_TOP = TAIL_W'(TAIL_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= CNT_W'(1);
        end else if (step && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tail <= '0;
        end else if (restart) begin
            tail <= '0;
        end else if (tail_start) begin
            tail <= TAIL_W'(1);
        end else if (tail_step && tail != TAIL_TOP) begin
            tail <= tail + 1'b1;
        end
    end
endmodule

// File: rtl/smws_fsm.sv
// Access state machine: state register, next-state logic and output decode.
module smws_fsm
    import smws_pkg::*;
#(
    parameter int CNT_W      = 5,
    parameter int TAIL_LEN   = 3,
    parameter int ARM_WINDOW = 2,
    localparam int TAIL_W    = $clog2(TAIL_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wait_n,
    input  logic              wr_q,
    input  logic [CNT_W-1:0]  limit_q,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [TAIL_W-1:0] tail,
    output logic              load,
    output logic              restart,
    output logic              step,
    output logic              tail_start,
    output logic              tail_step,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              done
);
    localparam logic [CNT_W-1:0]  WINDOW_END = CNT_W'(ARM_WINDOW);
    localparam logic [TAIL_W-1:0] TAIL_TOP   = TAIL_W'(TAIL_LEN);

    smws_state_e state_q, state_d;
    logic        count_met;
    logic        arm_now;

    always_comb begin
        count_met = (cnt >= limit_q);
        arm_now   = !wait_n && (cnt <= WINDOW_END);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        load       = 1'b0;
        restart    = 1'b0;
        step       = 1'b0;
        tail_start = 1'b0;
        tail_step  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    restart = 1'b1;
                    state_d = ST_COUNT;
                end
            end
            ST_COUNT: begin
                if (arm_now) begin
                    step    = 1'b1;
                    state_d = ST_STRETCH;
                end else if (count_met) begin
                    state_d = ST_DONE;
                end else begin
                    step = 1'b1;
                end
            end
            ST_STRETCH: begin
                step = 1'b1;
                if (wait_n) begin
                    tail_start = 1'b1;
                    state_d    = ST_TAIL;
                end
            end
            ST_TAIL: begin
                if (tail == TAIL_TOP && count_met) begin
                    state_d = ST_DONE;
                end else begin
                    step      = 1'b1;
                    tail_step = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        cs_n = 1'b1;
        done = 1'b0;
        unique case (state_q)
            ST_COUNT, ST_STRETCH, ST_TAIL: cs_n = 1'b0;
            ST_DONE:                       done = 1'b1;
            default:                       cs_n = 1'b1;
        endcase
        oe_n = cs_n | wr_q;
        we_n = cs_n | !wr_q;
    end
endmodule

// File: rtl/smws_top.sv
module smws_top #(
    parameter int CNT_W      = 5,
    parameter int MIN_WAITS  = 2,
    parameter int TAIL_LEN   = 3,
    parameter int ARM_WINDOW = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic             req_write,
    input  logic [CNT_W-1:0] req_waits,
    input  logic             ext_wait_n,
    output logic             mem_cs_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic             acc_done
);
    localparam int TAIL_W = $clog2(TAIL_LEN + 1);

    logic              load, restart, step, tail_start, tail_step;
    logic              wr_q;
    logic [CNT_W-1:0]  limit_q;
    logic [CNT_W-1:0]  cnt;
    logic [TAIL_W-1:0] tail;

    smws_cfg #(.CNT_W(CNT_W), .MIN_WAITS(MIN_WAITS)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .wr_in    (req_write),
        .waits_in (req_waits),
        .wr_q     (wr_q),
        .limit_q  (limit_q)
    );

    smws_counters #(.CNT_W(CNT_W), .TAIL_LEN(TAIL_LEN)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step       (step),
        .tail_start (tail_start),
        .tail_step  (tail_step),
        .cnt        (cnt),
        .tail       (tail)
    );

    smws_fsm #(.CNT_W(CNT_W), .TAIL_LEN(TAIL_LEN), .ARM_WINDOW(ARM_WINDOW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (req_start),
        .wait_n     (ext_wait_n),
        .wr_q       (wr_q),
        .limit_q    (limit_q),
        .cnt        (cnt),
        .tail       (tail),
        .load       (load),
        .restart    (restart),
        .step       (step),
        .tail_start (tail_start),
        .tail_step  (tail_step),
        .cs_n       (mem_cs_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .done       (acc_done)
    );
endmodule

// File: rtl/smws_checker.sv
module smws_checker (
    input logic clk,
    input logic rst_n,
    input logic req_start,
    input logic mem_cs_n,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic acc_done
);
    assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n));

    assert_strobe_needs_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_cs_n |-> (mem_oe_n && mem_we_n));

    assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_cs_n && !acc_done && req_start) |=> !mem_cs_n);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    assert_done_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> (mem_cs_n && $past(!mem_cs_n)));

    assert_done_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> mem_cs_n);

    assert_strobe_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_oe_n) && $stable(mem_we_n)));

    always_comb begin
        if (rst_n == 1'b0) begin
            assert_reset_idle_R8: assert (mem_cs_n && mem_oe_n && mem_we_n && !acc_done);
        end
    end
endmodule

bind smws_top smws_checker u_smws_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_start (req_start),
    .mem_cs_n  (mem_cs_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .acc_done  (acc_done)
);

// File: tb/smws_top_test.sv
`timescale 1ns/1ps
module smws_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0;
    logic       req_write = 1'b0;
    logic [4:0] req_waits = 5'd2;
    logic       ext_wait_n = 1'b1;
    logic       mem_cs_n, mem_oe_n, mem_we_n, acc_done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    smws_top uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_start  (req_start),
        .req_write  (req_write),
        .req_waits  (req_waits),
        .ext_wait_n (ext_wait_n),
        .mem_cs_n   (mem_cs_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .acc_done   (acc_done)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expected_len(input int n, input int a, input int r);
        int ne;
        int l;
        ne = (n < 2) ? 2 : n;
        l  = ne;
        if ((a == 1 || a == 2) && r > a) begin
            l = (r + 3 > ne) ? r + 3 : ne;
        end
        return l;
    endfunction

    // Runs one access; wait line low during active cycles a..r-1 (a=0: never).
    // poke: start pulse with changed fields in cycle 3 (R7, R9) and in the done cycle.
    task automatic run_access(input bit wr, input int n, input int a, input int r,
                              input bit poke, input string tag);
        int  exp_len;
        int  active;
        int  done_at;
        bit  strobe_ok;
        exp_len   = expected_len(n, a, r);
        active    = 0;
        done_at   = 0;
        strobe_ok = 1'b1;
        @(negedge clk);
        req_start  = 1'b1;
        req_write  = wr;
        req_waits  = 5'(n);
        ext_wait_n = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        for (int i = 1; i <= 200; i++) begin
            ext_wait_n = !(a != 0 && i >= a && i < r);
            if (poke && i == 3) begin
                req_start = 1'b1;
                req_write = !wr;
                req_waits = 5'd31;
            end else begin
                req_start = 1'b0;
            end
            if (acc_done) begin
                done_at = i;
                check(mem_cs_n && mem_oe_n && mem_we_n, {tag, " R6 outputs idle at done"},
                      {mem_cs_n, mem_oe_n, mem_we_n}, 7);
                break;
            end
            if (!mem_cs_n) begin
                active++;
                if (wr ? (mem_we_n || !mem_oe_n) : (mem_oe_n || !mem_we_n)) strobe_ok = 1'b0;
            end
            @(negedge clk);
        end
        ext_wait_n = 1'b1;
        check(strobe_ok, {tag, " R1 strobe matches direction"}, strobe_ok, 1);
        check(active == exp_len, {tag, " access length"}, active, exp_len);
        check(done_at == exp_len + 1, {tag, " R6 done cycle"}, done_at, exp_len + 1);
        if (poke) req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(!acc_done, {tag, " R6 done single cycle"}, acc_done, 0);
        if (poke) begin
            for (int k = 0; k < 3; k++) begin
                check(mem_cs_n, {tag, " R7 no extra access"}, mem_cs_n, 1);
                @(negedge clk);
            end
        end
        req_write = 1'b0;
        req_waits = 5'd2;
    endtask

    task automatic t_reset();
        #1;
        check(mem_cs_n && mem_oe_n && mem_we_n && !acc_done, "R8 reset outputs",
              {mem_cs_n, mem_oe_n, mem_we_n, acc_done}, 14);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_cs_n && !acc_done, "R8 idle after reset", mem_cs_n, 1);
    endtask

    task automatic t_first_cycle();
        @(negedge clk);
        req_start = 1'b1;
        req_write = 1'b1;
        req_waits = 5'd4;
        @(negedge clk);
        req_start = 1'b0;
        check(!mem_cs_n && !mem_we_n && mem_oe_n, "R1 cs and write strobe in first cycle",
              {mem_cs_n, mem_we_n, mem_oe_n}, 1);
        while (!acc_done) @(negedge clk);
        @(negedge clk);
        req_write = 1'b0;
    endtask

    initial begin
        t_reset();
        t_first_cycle();
        run_access(1'b0, 2, 0, 0, 1'b0, "R3 read n2");
        run_access(1'b1, 5, 0, 0, 1'b0, "R3 write n5");
        run_access(1'b0, 31, 0, 0, 1'b0, "R3 read n31");
        run_access(1'b0, 0, 0, 0, 1'b0, "R2 clamp n0");
        run_access(1'b1, 1, 0, 0, 1'b0, "R2 clamp n1");
        run_access(1'b0, 2, 2, 6, 1'b0, "R4 n2 wait cycle2");
        run_access(1'b1, 10, 1, 3, 1'b0, "R4 short release n10");
        run_access(1'b0, 3, 1, 20, 1'b0, "R4 long hold n3");
        run_access(1'b1, 4, 3, 10, 1'b0, "R5 late wait n4");
        run_access(1'b0, 2, 3, 12, 1'b0, "R5 late wait n2");
        run_access(1'b0, 6, 0, 0, 1'b1, "R7 R9 poke read");
        run_access(1'b1, 3, 2, 5, 1'b1, "R7 R9 poke write");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule